// File: doc/BRIEF.md
# Exception Entry Unit

This block decides, once per cycle, whether the core enters an exception or interrupt handler, and computes everything that changes on entry. The inputs are the current program counter, the live status word, the power-management word, a flag that marks an instruction in a branch delay slot, and a vector-base enable and value. Three request sources feed it: a synchronous exception request with a 4-bit cause code, an external interrupt line and a tick-timer interrupt line.

In the cycle an entry is accepted, the unit raises `take_o` for that one cycle. In the same cycle it presents the fetch redirect address, the new status word and the new power-management word, and pulses the delay-slot clear and the reservation kill. The saved PC, the saved status and the error address are held in the unit and change at the clock edge that ends the take cycle. Pipeline flushing, the return-from-exception path and the handlers themselves are left to the surrounding core.

Cause codes, fixed because the vector layout depends on them: 1 reset, 2 bus error, 3 data page fault, 4 instruction page fault, 5 tick timer, 6 alignment, 7 illegal instruction, 8 external interrupt, 9 data TLB miss, 10 instruction TLB miss, 11 range, 12 system call, 13 floating point, 14 trap. Status bit positions: 0 supervisor, 1 tick enable, 2 interrupt enable, 5 data-MMU enable, 6 instruction-MMU enable, 13 delay-slot-exception, 14 high exception page. Power-management bit positions: 4 doze, 5 sleep.

Top module: `exc_entry_unit`

## Requirements
- R1: On a take, `epcr_o` is loaded at the next edge with `pc_i`, or with `pc_i`+4 when the taken code is 12 (system call), before any delay-slot correction.
- R2: When `dslot_i` is high on a take, 4 is subtracted from the saved PC, `sr_next_o` bit 13 is set and `dslot_clr_o` pulses. When `dslot_i` is low, `sr_next_o` bit 13 is 0 and `dslot_clr_o` stays low.
- R3: A take with code 7 (illegal instruction) loads `eear_o` with `pc_i`. Any other take, or a cycle without a take, leaves `eear_o` unchanged.
- R4: On a take, `esr_o` is loaded with the value of `sr_i` from the take cycle. `sr_next_o` equals `sr_i` with bits 1, 2, 5 and 6 cleared and bit 0 set.
- R5: On a take, `pmr_next_o` equals `pmr_i` with bits 4 and 5 cleared, and `lock_kill_o` pulses for that cycle.
- R6: `redir_pc_o` is the taken code shifted left by 8. `vbase_i` is ORed in when `vbase_en_i` is high, and 0xF0000000 is ORed in when `sr_i` bit 14 is high.
- R7: A synchronous request with code 0 or 15 raises `err_o` for that cycle, produces no take even if an interrupt is pending, and leaves all saved registers unchanged.
- R8: An external interrupt is taken as code 8 only when `sr_i` bit 2 is set. A tick interrupt is taken as code 5 only when `sr_i` bit 1 is set. When both are pending and enabled, the tick interrupt wins.
- R9: A synchronous request with a valid code wins over any pending interrupt in the same cycle, and its code is the one taken.
- R10: Without a take, `take_o`, `dslot_clr_o` and `lock_kill_o` are low, `sr_next_o` equals `sr_i`, `pmr_next_o` equals `pmr_i`, and `epcr_o`, `esr_o` and `eear_o` hold their values.
- R11: While reset is asserted, `epcr_o`, `esr_o` and `eear_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pc_i | input | XLEN | PC of the instruction being retired or faulting |
| sr_i | input | SR_W | Live status word |
| pmr_i | input | PMR_W | Live power-management word |
| dslot_i | input | 1 | Current instruction is in a branch delay slot |
| vbase_en_i | input | 1 | Configuration: vector base register present |
| vbase_i | input | XLEN | Vector base register |
| ext_irq_i | input | 1 | External interrupt pending |
| tick_irq_i | input | 1 | Tick-timer interrupt pending |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 4 | Cause code of the synchronous request |
| take_o | output | 1 | Entry accepted this cycle; redirect valid |
| take_code_o | output | 4 | Code of the accepted entry (0 when none) |
| err_o | output | 1 | Synchronous request carried an invalid code |
| redir_pc_o | output | XLEN | Fetch redirect address |
| sr_next_o | output | SR_W | Status word to write back |
| pmr_next_o | output | PMR_W | Power-management word to write back |
| dslot_clr_o | output | 1 | Clear the core's delay-slot flag |
| lock_kill_o | output | 1 | Invalidate the load-link reservation |
| epcr_o | output | XLEN | Saved exception PC |
| esr_o | output | SR_W | Saved status word |
| eear_o | output | XLEN | Error effective address |

## Verification
A wrong pick in the arbiter shows up in the same cycle. Either `take_code_o` and `redir_pc_o` disagree with the winning source, or `take_o` rises while an error is flagged. An error in the saved-context registers shows up one edge after the take, in `epcr_o`, `esr_o` or `eear_o`. A register that moves without a take is visible at the very next edge, because those outputs must hold. Delay-slot and system-call corrections are exercised together, so an offset with the wrong sign or applied at the wrong time is caught by the first entry that combines them.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    CAUSE_NONE    = 4'd0,
    CAUSE_RESET   = 4'd1,
    CAUSE_BUSERR  = 4'd2,
    CAUSE_DPFAULT = 4'd3,
    CAUSE_IPFAULT = 4'd4,
    CAUSE_TICK    = 4'd5,
    CAUSE_ALIGN   = 4'd6,
    CAUSE_ILLEGAL = 4'd7,
    CAUSE_EXTINT  = 4'd8,
    CAUSE_DTMISS  = 4'd9,
    CAUSE_ITMISS  = 4'd10,
    CAUSE_RANGE   = 4'd11,
    CAUSE_SYSCALL = 4'd12,
    CAUSE_FPU     = 4'd13,
    CAUSE_TRAP    = 4'd14
  } cause_e;

  localparam logic [CODE_W-1:0] CAUSE_FIRST = CAUSE_RESET;
  localparam logic [CODE_W-1:0] CAUSE_LAST  = CAUSE_TRAP;

  // status word bit positions
  localparam int ST_SUPER = 0;
  localparam int ST_TICKE = 1;
  localparam int ST_INTE  = 2;
  localparam int ST_DMMU  = 5;
  localparam int ST_IMMU  = 6;
  localparam int ST_DSLOT = 13;
  localparam int ST_HIPG  = 14;

  // power-management bit positions
  localparam int PM_DOZE  = 4;
  localparam int PM_SLEEP = 5;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SYNC = 2'd1,
    SRC_TICK = 2'd2,
    SRC_EXT  = 2'd3
  } src_e;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              ext_i,
  input  logic              tick_i,
  input  logic              inte_i,
  input  logic              ticke_i,
  output logic              take_o,
  output logic              err_o,
  output logic [CODE_W-1:0] code_o
);

  logic code_ok;
  src_e src;

  assign code_ok = (code_i >= CAUSE_FIRST) && (code_i <= CAUSE_LAST);

  always_comb begin
    src   = SRC_NONE;
    err_o = 1'b0;
    if (req_i) begin
      if (code_ok) src = SRC_SYNC;
      else         err_o = 1'b1;
    end else if (tick_i && ticke_i) begin
      src = SRC_TICK;
    end else if (ext_i && inte_i) begin
      src = SRC_EXT;
    end
  end

  always_comb begin
    unique case (src)
      SRC_SYNC: code_o = code_i;
      SRC_TICK: code_o = CAUSE_TICK;
      SRC_EXT:  code_o = CAUSE_EXTINT;
      default:  code_o = CAUSE_NONE;
    endcase
  end

  assign take_o = (src != SRC_NONE);

  a_r7_err_blocks_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !take_o);
  a_r8_ext_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && code_o == CAUSE_EXTINT && !req_i) |-> inte_i);
  a_r8_tick_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && tick_i && ticke_i) |-> (take_o && code_o == CAUSE_TICK));
  a_r9_sync_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !err_o) |-> (take_o && code_o == code_i));

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int VEC_SHIFT = 8,
  parameter int HIPG_BITS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              base_en_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic              hipg_i,
  output logic [XLEN-1:0]   vec_o
);

  localparam logic [XLEN-1:0] HIPG_MASK = {{HIPG_BITS{1'b1}}, {(XLEN-HIPG_BITS){1'b0}}};

  logic [XLEN-1:0] offs;

  assign offs = XLEN'(code_i) << VEC_SHIFT;

  always_comb begin
    vec_o = offs;
    if (base_en_i) vec_o = vec_o | base_i;
    if (hipg_i)    vec_o = vec_o | HIPG_MASK;
  end

  a_r6_low_bits_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !base_en_i |-> (vec_o[VEC_SHIFT-1:0] == '0));
  a_r6_high_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hipg_i |-> (vec_o[XLEN-1 -: HIPG_BITS] == {HIPG_BITS{1'b1}}));

endmodule

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs
  import exc_entry_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int SR_W  = 16,
  parameter int PMR_W = 8,
  parameter int ISTEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [SR_W-1:0]   sr_i,
  input  logic [PMR_W-1:0]  pmr_i,
  input  logic              dslot_i,
  output logic [SR_W-1:0]   sr_next_o,
  output logic [PMR_W-1:0]  pmr_next_o,
  output logic              dslot_clr_o,
  output logic              lock_kill_o,
  output logic [XLEN-1:0]   epcr_o,
  output logic [SR_W-1:0]   esr_o,
  output logic [XLEN-1:0]   eear_o
);

  localparam logic [XLEN-1:0] STEP = XLEN'(ISTEP);

  logic [XLEN-1:0] epcr_q, epcr_d, eear_q, eear_d, epc_calc;
  logic [SR_W-1:0] esr_q, esr_d;
  logic            epcr_en, eear_en;

  always_comb begin
    epc_calc = pc_i;
    if (code_i == CAUSE_SYSCALL) epc_calc = epc_calc + STEP;
    if (dslot_i)                 epc_calc = epc_calc - STEP;
  end

  assign epcr_en = take_i;
  assign eear_en = take_i && (code_i == CAUSE_ILLEGAL);
  assign epcr_d  = epc_calc;
  assign esr_d   = sr_i;
  assign eear_d  = pc_i;

  always_comb begin
    sr_next_o  = sr_i;
    pmr_next_o = pmr_i;
    if (take_i) begin
      sr_next_o[ST_DMMU]   = 1'b0;
      sr_next_o[ST_IMMU]   = 1'b0;
      sr_next_o[ST_INTE]   = 1'b0;
      sr_next_o[ST_TICKE]  = 1'b0;
      sr_next_o[ST_SUPER]  = 1'b1;
      sr_next_o[ST_DSLOT]  = dslot_i;
      pmr_next_o[PM_DOZE]  = 1'b0;
      pmr_next_o[PM_SLEEP] = 1'b0;
    end
  end

  assign dslot_clr_o = take_i && dslot_i;
  assign lock_kill_o = take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epcr_q <= '0;
      esr_q  <= '0;
    end else if (epcr_en) begin
      epcr_q <= epcr_d;
      esr_q  <= esr_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      eear_q <= '0;
    else if (eear_en) eear_q <= eear_d;
  end

  assign epcr_o = epcr_q;
  assign esr_o  = esr_q;
  assign eear_o = eear_q;

  a_r1_epc_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !dslot_i && code_i != CAUSE_SYSCALL) |=> (epcr_o == $past(pc_i)));
  a_r1_epc_syscall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !dslot_i && code_i == CAUSE_SYSCALL) |=> (epcr_o == $past(pc_i) + STEP));
  a_r2_dslot_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (sr_next_o[ST_DSLOT] == dslot_i));
  a_r3_eear_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(take_i && code_i == CAUSE_ILLEGAL) |=> $stable(eear_o));
  a_r4_esr_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (esr_o == $past(sr_i)));
  a_r4_supervisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (sr_next_o[ST_SUPER] && !sr_next_o[ST_INTE] && !sr_next_o[ST_TICKE]));
  a_r10_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> ($stable(epcr_o) && $stable(esr_o)));

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int SR_W  = 16,
  parameter int PMR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [SR_W-1:0]   sr_i,
  input  logic [PMR_W-1:0]  pmr_i,
  input  logic              dslot_i,
  input  logic              vbase_en_i,
  input  logic [XLEN-1:0]   vbase_i,
  input  logic              ext_irq_i,
  input  logic              tick_irq_i,
  input  logic              exc_req_i,
  input  logic [CODE_W-1:0] exc_code_i,
  output logic              take_o,
  output logic [CODE_W-1:0] take_code_o,
  output logic              err_o,
  output logic [XLEN-1:0]   redir_pc_o,
  output logic [SR_W-1:0]   sr_next_o,
  output logic [PMR_W-1:0]  pmr_next_o,
  output logic              dslot_clr_o,
  output logic              lock_kill_o,
  output logic [XLEN-1:0]   epcr_o,
  output logic [SR_W-1:0]   esr_o,
  output logic [XLEN-1:0]   eear_o
);

  logic              take;
  logic [CODE_W-1:0] code;

  exc_arbiter u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (exc_req_i),
    .code_i  (exc_code_i),
    .ext_i   (ext_irq_i),
    .tick_i  (tick_irq_i),
    .inte_i  (sr_i[ST_INTE]),
    .ticke_i (sr_i[ST_TICKE]),
    .take_o  (take),
    .err_o   (err_o),
    .code_o  (code)
  );

  exc_vector_gen #(.XLEN(XLEN)) u_vec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_i    (code),
    .base_en_i (vbase_en_i),
    .base_i    (vbase_i),
    .hipg_i    (sr_i[ST_HIPG]),
    .vec_o     (redir_pc_o)
  );

  exc_ctx_regs #(.XLEN(XLEN), .SR_W(SR_W), .PMR_W(PMR_W)) u_ctx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take),
    .code_i      (code),
    .pc_i        (pc_i),
    .sr_i        (sr_i),
    .pmr_i       (pmr_i),
    .dslot_i     (dslot_i),
    .sr_next_o   (sr_next_o),
    .pmr_next_o  (pmr_next_o),
    .dslot_clr_o (dslot_clr_o),
    .lock_kill_o (lock_kill_o),
    .epcr_o      (epcr_o),
    .esr_o       (esr_o),
    .eear_o      (eear_o)
  );

  assign take_o      = take;
  assign take_code_o = code;

  a_r5_kill_with_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_kill_o == take_o);

endmodule

// File: tb/tb_exc_entry_unit.sv
`timescale 1ns/1ps
module tb_exc_entry_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc, vbase;
  logic [15:0] sr;
  logic [7:0]  pmr;
  logic        dslot, vbase_en, ext_irq, tick_irq, exc_req;
  logic [3:0]  exc_code;
  logic        take, err, dslot_clr, lock_kill;
  logic [3:0]  take_code;
  logic [31:0] redir_pc, epcr, eear;
  logic [15:0] sr_next, esr;
  logic [7:0]  pmr_next;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_epcr = 0, m_eear = 0;
  logic [15:0] m_esr = 0;

  always #2.5 clk = ~clk;

  exc_entry_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .sr_i(sr), .pmr_i(pmr),
    .dslot_i(dslot), .vbase_en_i(vbase_en), .vbase_i(vbase),
    .ext_irq_i(ext_irq), .tick_irq_i(tick_irq), .exc_req_i(exc_req),
    .exc_code_i(exc_code), .take_o(take), .take_code_o(take_code),
    .err_o(err), .redir_pc_o(redir_pc), .sr_next_o(sr_next),
    .pmr_next_o(pmr_next), .dslot_clr_o(dslot_clr), .lock_kill_o(lock_kill),
    .epcr_o(epcr), .esr_o(esr), .eear_o(eear)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic [31:0] p, input logic [15:0] s, input logic [7:0] pm,
                       input logic ds, input logic ve, input logic [31:0] vb,
                       input logic ei, input logic ti, input logic rq, input logic [3:0] cd);
    logic       e_take, e_err;
    logic [3:0] e_code;
    logic [31:0] e_vec, e_epc;
    logic [15:0] e_sr;
    logic [7:0]  e_pm;
    @(negedge clk);
    pc = p; sr = s; pmr = pm; dslot = ds; vbase_en = ve; vbase = vb;
    ext_irq = ei; tick_irq = ti; exc_req = rq; exc_code = cd;
    #1;
    e_take = 0; e_err = 0; e_code = 0;
    if (rq) begin
      if (cd >= 1 && cd <= 14) begin e_take = 1; e_code = cd; end
      else e_err = 1;
    end else if (ti && s[1]) begin e_take = 1; e_code = 5; end
    else if (ei && s[2]) begin e_take = 1; e_code = 8; end
    e_vec = {24'd0, e_code, 4'd0} << 4;
    if (ve) e_vec = e_vec | vb;
    if (s[14]) e_vec = e_vec | 32'hF000_0000;
    e_sr = s; e_pm = pm;
    if (e_take) begin
      e_sr[1] = 0; e_sr[2] = 0; e_sr[5] = 0; e_sr[6] = 0; e_sr[0] = 1; e_sr[13] = ds;
      e_pm[4] = 0; e_pm[5] = 0;
    end
    e_epc = p + ((e_code == 12) ? 32'd4 : 32'd0) - (ds ? 32'd4 : 32'd0);
    chk("R7", "err", {31'd0, err}, {31'd0, e_err});
    chk("R9", "take", {31'd0, take}, {31'd0, e_take});
    chk("R8", "code", {28'd0, take_code}, {28'd0, e_code});
    if (e_take) chk("R6", "vector", redir_pc, e_vec);
    chk("R4", "sr_next", {16'd0, sr_next}, {16'd0, e_sr});
    chk("R5", "pmr_next", {24'd0, pmr_next}, {24'd0, e_pm});
    chk("R5", "lock_kill", {31'd0, lock_kill}, {31'd0, e_take});
    chk("R2", "dslot_clr", {31'd0, dslot_clr}, {31'd0, e_take & ds});
    if (e_take) begin
      m_epcr = e_epc; m_esr = s;
      if (e_code == 7) m_eear = p;
    end
    @(posedge clk); #1;
    chk("R1", "epcr", epcr, m_epcr);
    chk("R4", "esr", {16'd0, esr}, {16'd0, m_esr});
    chk("R3", "eear", eear, m_eear);
    if (!e_take) chk("R10", "idle hold epcr", epcr, m_epcr);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    pc = 0; sr = 0; pmr = 0; dslot = 0; vbase_en = 0; vbase = 0;
    ext_irq = 0; tick_irq = 0; exc_req = 0; exc_code = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "reset epcr", epcr, 0);
    chk("R11", "reset esr", {16'd0, esr}, 0);
    chk("R11", "reset eear", eear, 0);
    chk("R10", "reset take", {31'd0, take}, 0);
    @(negedge clk); rst_n = 1;

    // R1 plain and syscall
    drive(32'h0000_1000, 16'h0006, 8'h30, 0, 0, 0, 0, 0, 1, 4'd2);
    drive(32'h0000_2000, 16'h0006, 8'h00, 0, 0, 0, 0, 0, 1, 4'd12);
    // R2 syscall in delay slot, and plain delay slot
    drive(32'h0000_3004, 16'h2000, 8'h00, 1, 0, 0, 0, 0, 1, 4'd12);
    drive(32'h0000_3104, 16'h0000, 8'h00, 1, 0, 0, 0, 0, 1, 4'd6);
    // R3 illegal loads eear, then trap leaves it
    drive(32'h0000_4440, 16'h0000, 8'h00, 0, 0, 0, 0, 0, 1, 4'd7);
    drive(32'h0000_5550, 16'h0000, 8'h00, 0, 0, 0, 0, 0, 1, 4'd14);
    // R7 invalid codes with interrupts pending
    drive(32'h0000_6000, 16'h0006, 8'h00, 0, 0, 0, 1, 1, 1, 4'd0);
    drive(32'h0000_6100, 16'h0006, 8'h00, 0, 0, 0, 1, 1, 1, 4'd15);
    // R8 gating and tick priority
    drive(32'h0000_7000, 16'h0000, 8'h00, 0, 0, 0, 1, 1, 0, 4'd0);
    drive(32'h0000_7100, 16'h0004, 8'h00, 0, 0, 0, 1, 1, 0, 4'd0);
    drive(32'h0000_7200, 16'h0006, 8'h30, 0, 0, 0, 1, 1, 0, 4'd0);
    drive(32'h0000_7300, 16'h0002, 8'h00, 0, 0, 0, 1, 0, 0, 4'd0);
    // R9 sync over interrupts
    drive(32'h0000_8000, 16'h0006, 8'h00, 0, 0, 0, 1, 1, 1, 4'd3);
    // R6 base and high page
    drive(32'h0000_9000, 16'h4000, 8'h00, 0, 1, 32'h0012_0000, 0, 0, 1, 4'd14);
    drive(32'h0000_9100, 16'h0000, 8'h00, 0, 1, 32'h0034_0000, 0, 0, 1, 4'd1);

    for (int i = 0; i < 1500; i++) begin
      logic [31:0] rp = $urandom & 32'hFFFF_FFFC;
      logic [15:0] rs = 16'($urandom);
      logic [7:0]  rm = 8'($urandom);
      logic [31:0] rv = $urandom & 32'hFFFF_E000;
      logic        rq = ($urandom % 3) == 0;
      drive(rp, rs, rm, 1'($urandom), 1'($urandom), rv, 1'($urandom), 1'($urandom),
            rq, 4'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule